// File: doc/BRIEF.md
# Cumulative Row Boundary Decoder

This block decides which of eight DRAM rows owns a physical address. Software programs eight byte-wide boundary values. Each value is the running total of memory in rows 0 through n, counted in 8 MB units, so the last value is the top of memory. The decoder compares the 8 MB chunk index of the address, taken from address bits [30:23], against those totals. It returns a one-hot row select and a hit flag.

Two fixed windows can be removed from DRAM through a 2-bit hole code. One is the 128 KB window from 512 KB to 640 KB. The other is the 1 MB window from 15 MB to 16 MB. An address inside an enabled window is flagged as routed away from DRAM, and so is any address at or above the top of memory. The memory controller then sends that access elsewhere instead of to a row.

The decoder takes one address per cycle when the valid strobe is high. It registers the result once, so each answer appears one clock later.

Top module: `row_span_decoder`

## Requirements
- R1: While reset is held and after it is released, with no valid strobe, all outputs (`rowSel`, `rowHit`, `offDram`, `decValid`) are zero.
- R2: An address sampled with `addrValid` high produces its result and `decValid` high on the next clock edge. Back-to-back strobes give back-to-back results. A cycle without a strobe drives `decValid`, `rowSel`, `rowHit` and `offDram` to zero at the following edge.
- R3: Boundary byte n sits at `bndFlat[8n+7:8n]` and holds the cumulative size of rows 0..n in 8 MB units. Row n is selected when address bits [30:23] are at or above boundary n-1 and below boundary n; row 0's lower bound is zero. Bit n of `rowSel` marks row n.
- R4: A row whose boundary equals the boundary of the row before it (for row 0, a boundary of zero) is never selected; addresses fall to the next row that has space.
- R5: An address whose bits [30:23] are at or above boundary 7, or whose bit 31 is set, gives `rowHit` low, `rowSel` zero and `offDram` high.
- R6: With hole code 2'b01, addresses 0x0008_0000 to 0x0009_FFFF give `offDram` high and no row. Addresses just outside that window decode normally.
- R7: With hole code 2'b10, addresses 0x00F0_0000 to 0x00FF_FFFF give `offDram` high and no row. Addresses just outside that window decode normally.
- R8: Hole codes 2'b00 and the reserved 2'b11 remove no addresses.
- R9: For every valid result exactly one of `rowHit` and `offDram` is high. `rowSel` has at most one bit set, and it is nonzero exactly when `rowHit` is high.
- R10: If misprogrammed boundaries let an address match more than one row, the lowest-numbered matching row is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrIn | input | 32 | Physical address to decode |
| addrValid | input | 1 | Address strobe; sample `addrIn` this cycle |
| bndFlat | input | 64 | Eight cumulative row boundaries, byte n for row n, 8 MB units |
| holeMode | input | 2 | Hole select: 00 none, 01 512–640 KB, 10 15–16 MB, 11 reserved (none) |
| rowSel | output | 8 | One-hot selected row, registered |
| rowHit | output | 1 | Address landed in a populated row |
| offDram | output | 1 | Address is in an enabled hole or above top of memory |
| decValid | output | 1 | Result registers hold a fresh decode |

## Verification
The result registers are the block's only state. A wrong value in them shows up at the ports one edge after the strobe that loaded it. The symptom is a row bit that disagrees with the boundary arithmetic, `rowHit` and `offDram` both high or both low, or stale outputs left over after an idle cycle. A compare that is off by one on an inclusive or exclusive bound is caught only at chunk indices equal to a boundary value and at the first and last byte of each hole window. So the directed tests target those exact addresses, including empty rows and a non-increasing boundary list.

// File: rtl/row_span_pkg.sv
package row_span_pkg;

  typedef enum logic [1:0] {
    HOLE_NONE    = 2'b00,
    HOLE_BASEMEM = 2'b01,
    HOLE_FIFTEEN = 2'b10,
    HOLE_RSVD    = 2'b11
  } hole_mode_e;

  localparam logic [31:0] HOLE_LO_BASE = 32'h0008_0000;
  localparam logic [31:0] HOLE_LO_END  = 32'h000A_0000;
  localparam logic [31:0] HOLE_HI_BASE = 32'h00F0_0000;
  localparam logic [31:0] HOLE_HI_END  = 32'h0100_0000;

  typedef struct packed {
    logic load;
    logic clear;
  } dec_strobe_t;

endpackage

// File: rtl/row_span_ctrl.sv
module row_span_ctrl
  import row_span_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        addrValid,
  output dec_strobe_t strobe,
  output logic        decValid
);

  always_comb begin
    strobe.load  = addrValid;
    strobe.clear = !addrValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) decValid <= 1'b0;
    else       decValid <= addrValid;
  end

endmodule

// File: rtl/row_span_datapath.sv
module row_span_datapath
  import row_span_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_ROWS   = 8,
  parameter int BND_W      = 8,
  parameter int GRAN_SHIFT = 23
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         addrIn,
  input  logic [NUM_ROWS*BND_W-1:0] bndFlat,
  input  logic [1:0]                holeMode,
  input  dec_strobe_t               strobe,
  output logic [NUM_ROWS-1:0]       rowSel,
  output logic                      rowHit,
  output logic                      offDram
);

  localparam int CHUNK_LSB = GRAN_SHIFT;
  localparam int CHUNK_MSB = GRAN_SHIFT + BND_W - 1;

  logic [BND_W-1:0]    chunk;
  logic                upperSet;
  logic [BND_W-1:0]    bnd [NUM_ROWS];
  logic [NUM_ROWS-1:0] rowMatch;
  logic [NUM_ROWS-1:0] rowPick;
  logic                inHole;
  logic                aboveTop;
  logic                awayNext;
  logic [NUM_ROWS-1:0] selNext;

  assign chunk    = addrIn[CHUNK_MSB:CHUNK_LSB];
  assign upperSet = |addrIn[ADDR_W-1:CHUNK_MSB+1];

  // One range comparator per row; row 0 starts at zero.
  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
    assign bnd[g] = bndFlat[g*BND_W +: BND_W];
    if (g == 0) begin : g_first
      assign rowMatch[g] = chunk < bnd[g];
    end else begin : g_rest
      assign rowMatch[g] = (chunk >= bnd[g-1]) && (chunk < bnd[g]);
    end
  end

  // Isolate the lowest set bit so overlapping ranges still give one row.
  assign rowPick = rowMatch & (~rowMatch + NUM_ROWS'(1));

  always_comb begin
    inHole = 1'b0;
    case (holeMode)
      HOLE_BASEMEM: inHole = (addrIn >= ADDR_W'(HOLE_LO_BASE)) &&
                             (addrIn <  ADDR_W'(HOLE_LO_END));
      HOLE_FIFTEEN: inHole = (addrIn >= ADDR_W'(HOLE_HI_BASE)) &&
                             (addrIn <  ADDR_W'(HOLE_HI_END));
      default:      inHole = 1'b0;
    endcase
  end

  assign aboveTop = upperSet || (chunk >= bnd[NUM_ROWS-1]);
  assign awayNext = inHole || aboveTop;
  assign selNext  = awayNext ? '0 : rowPick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowSel  <= '0;
      rowHit  <= 1'b0;
      offDram <= 1'b0;
    end else if (strobe.load) begin
      rowSel  <= selNext;
      rowHit  <= |selNext;
      offDram <= awayNext;
    end else if (strobe.clear) begin
      rowSel  <= '0;
      rowHit  <= 1'b0;
      offDram <= 1'b0;
    end
  end

endmodule

// File: rtl/row_span_decoder.sv
module row_span_decoder
  import row_span_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_ROWS   = 8,
  parameter int BND_W      = 8,
  parameter int GRAN_SHIFT = 23
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         addrIn,
  input  logic                      addrValid,
  input  logic [NUM_ROWS*BND_W-1:0] bndFlat,
  input  logic [1:0]                holeMode,
  output logic [NUM_ROWS-1:0]       rowSel,
  output logic                      rowHit,
  output logic                      offDram,
  output logic                      decValid
);

  dec_strobe_t strobe;

  row_span_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .addrValid (addrValid),
    .strobe    (strobe),
    .decValid  (decValid)
  );

  row_span_datapath #(
    .ADDR_W     (ADDR_W),
    .NUM_ROWS   (NUM_ROWS),
    .BND_W      (BND_W),
    .GRAN_SHIFT (GRAN_SHIFT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .addrIn   (addrIn),
    .bndFlat  (bndFlat),
    .holeMode (holeMode),
    .strobe   (strobe),
    .rowSel   (rowSel),
    .rowHit   (rowHit),
    .offDram  (offDram)
  );

endmodule

// File: rtl/row_span_decoder_chk.sv
module row_span_decoder_chk (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] addrIn,
  input logic        addrValid,
  input logic [63:0] bndFlat,
  input logic [1:0]  holeMode,
  input logic [7:0]  rowSel,
  input logic        rowHit,
  input logic        offDram,
  input logic        decValid
);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |=> decValid);

  a_r2_idle_clears: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |=> (!decValid && rowSel == 8'h00 && !rowHit && !offDram));

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    decValid |-> (rowHit != offDram));

  a_r9_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rowSel) && (rowHit == (rowSel != 8'h00)));

  a_r5_high_bit: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && addrIn[31]) |=> (offDram && !rowHit));

  a_r6_low_hole: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && holeMode == 2'b01 && addrIn >= 32'h0008_0000 &&
     addrIn < 32'h000A_0000) |=> (offDram && !rowHit));

  a_r7_high_hole: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && holeMode == 2'b10 && addrIn >= 32'h00F0_0000 &&
     addrIn < 32'h0100_0000) |=> (offDram && !rowHit));

  a_r4_empty_row: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && bndFlat[15:8] == bndFlat[7:0]) |=> !rowSel[1]);

endmodule

bind row_span_decoder row_span_decoder_chk u_chk (.*);

// File: tb/row_span_decoder_bench.sv
`timescale 1ns/1ps
module row_span_decoder_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] addrIn = '0;
  logic        addrValid = 1'b0;
  logic [63:0] bndFlat = '0;
  logic [1:0]  holeMode = 2'b00;
  logic [7:0]  rowSel;
  logic        rowHit;
  logic        offDram;
  logic        decValid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  row_span_decoder u_row_span_decoder (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .addrValid(addrValid),
    .bndFlat(bndFlat), .holeMode(holeMode), .rowSel(rowSel),
    .rowHit(rowHit), .offDram(offDram), .decValid(decValid)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic setBounds(input logic [7:0] b0, b1, b2, b3, b4, b5, b6, b7);
    bndFlat = {b7, b6, b5, b4, b3, b2, b1, b0};
  endtask

  // Drive one address, check the registered result one edge later.
  task automatic decodeOne(input logic [31:0] addr, input logic [7:0] expSel,
                           input bit expOff, input string tag);
    @(negedge clk);
    addrIn = addr;
    addrValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    addrValid = 1'b0;
    check(rowSel == expSel, {tag, " rowSel"}, {24'h0, rowSel}, {24'h0, expSel});
    check(offDram == expOff, {tag, " offDram"}, {31'h0, offDram}, {31'h0, expOff});
    check(rowHit == !expOff, {tag, " rowHit (R9)"}, {31'h0, rowHit}, {31'h0, !expOff});
    check(decValid == 1'b1, {tag, " decValid (R2)"}, {31'h0, decValid}, 32'h1);
  endtask

  task automatic testReset();
    @(negedge clk);
    check({rowSel, rowHit, offDram, decValid} == 11'h0, "R1 reset outputs",
          {21'h0, rowSel, rowHit, offDram, decValid}, 32'h0);
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check({rowSel, rowHit, offDram, decValid} == 11'h0, "R1 idle after reset",
          {21'h0, rowSel, rowHit, offDram, decValid}, 32'h0);
  endtask

  task automatic testRows();
    setBounds(8'd2, 8'd4, 8'd4, 8'd7, 8'd8, 8'd8, 8'd12, 8'd16);
    holeMode = 2'b00;
    decodeOne(32'h0000_0000, 8'h01, 1'b0, "R3 addr zero");
    decodeOne(32'h00FF_FFFF, 8'h01, 1'b0, "R3 row0 last");
    decodeOne(32'h0100_0000, 8'h02, 1'b0, "R3 row1 first");
    decodeOne(32'h0200_0000, 8'h08, 1'b0, "R4 skip empty row2");
    decodeOne(32'h0380_0000, 8'h10, 1'b0, "R3 row4");
    decodeOne(32'h0400_0000, 8'h40, 1'b0, "R4 skip empty row5");
    decodeOne(32'h07FF_FFFF, 8'h80, 1'b0, "R3 row7 last");
  endtask

  task automatic testTop();
    decodeOne(32'h0800_0000, 8'h00, 1'b1, "R5 at top");
    decodeOne(32'h7FFF_FFFF, 8'h00, 1'b1, "R5 chunk 255");
    decodeOne(32'h8000_0000, 8'h00, 1'b1, "R5 bit31");
    setBounds(8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0);
    decodeOne(32'h0000_0000, 8'h00, 1'b1, "R5 no memory");
    setBounds(8'd0, 8'd2, 8'd2, 8'd2, 8'd2, 8'd2, 8'd2, 8'd2);
    decodeOne(32'h0000_0000, 8'h02, 1'b0, "R4 empty row0");
  endtask

  task automatic testHoles();
    setBounds(8'd2, 8'd4, 8'd4, 8'd7, 8'd8, 8'd8, 8'd12, 8'd16);
    holeMode = 2'b01;
    decodeOne(32'h0007_FFFF, 8'h01, 1'b0, "R6 below low hole");
    decodeOne(32'h0008_0000, 8'h00, 1'b1, "R6 low hole first");
    decodeOne(32'h0009_FFFF, 8'h00, 1'b1, "R6 low hole last");
    decodeOne(32'h000A_0000, 8'h01, 1'b0, "R6 above low hole");
    decodeOne(32'h00F0_0000, 8'h01, 1'b0, "R6 high window open");
    holeMode = 2'b10;
    decodeOne(32'h00EF_FFFF, 8'h01, 1'b0, "R7 below high hole");
    decodeOne(32'h00F0_0000, 8'h00, 1'b1, "R7 high hole first");
    decodeOne(32'h00FF_FFFF, 8'h00, 1'b1, "R7 high hole last");
    decodeOne(32'h0100_0000, 8'h02, 1'b0, "R7 above high hole");
    decodeOne(32'h0008_0000, 8'h01, 1'b0, "R7 low window open");
    holeMode = 2'b11;
    decodeOne(32'h0008_0000, 8'h01, 1'b0, "R8 reserved low");
    decodeOne(32'h00F0_0000, 8'h01, 1'b0, "R8 reserved high");
    holeMode = 2'b00;
    decodeOne(32'h0009_0000, 8'h01, 1'b0, "R8 none low");
    decodeOne(32'h00F8_0000, 8'h01, 1'b0, "R8 none high");
  endtask

  task automatic testStream();
    // Back-to-back strobes, then an idle cycle.
    @(negedge clk);
    addrIn = 32'h0100_0000;
    addrValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(rowSel == 8'h02 && decValid, "R2 stream first", {24'h0, rowSel}, 32'h2);
    addrIn = 32'h0600_0000;
    @(posedge clk);
    @(negedge clk);
    check(rowSel == 8'h80 && decValid, "R2 stream second", {24'h0, rowSel}, 32'h80);
    addrValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check({rowSel, rowHit, offDram, decValid} == 11'h0, "R2 idle clears",
          {21'h0, rowSel, rowHit, offDram, decValid}, 32'h0);
  endtask

  task automatic testOverlap();
    setBounds(8'd10, 8'd5, 8'd20, 8'd20, 8'd20, 8'd20, 8'd20, 8'd20);
    decodeOne(32'h0300_0000, 8'h01, 1'b0, "R10 overlap lowest wins");
    decodeOne(32'h0600_0000, 8'h04, 1'b0, "R10 row2 only");
  endtask

  initial begin
    testReset();
    testRows();
    testTop();
    testHoles();
    testStream();
    testOverlap();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule